// File: doc/BRIEF.md
# Registered Eight-Bit Arithmetic Logic Unit

This block is a single-stage, fully registered arithmetic logic unit. Each clock edge captures two operands and a four-bit function code in input flops. A combinational stage then evaluates either an addition or one of nine bitwise logic functions, and the next edge captures the answer in output flops. Addition uses a parallel-prefix carry network of the Brent-Kung kind. A carry-out bit goes with the sum.

The unit accepts a new operation on every clock. The caller presents an operand pair and a function code, and the matching result appears on the outputs two rising edges later. Operations presented on successive cycles leave in the same order, one per cycle. An active-high synchronous reset clears every register in the block.

Top module: `alu_top`

## Requirements
- R1: While reset is high at a rising edge, every input and output register clears. After that edge, `result` and `carryOut` read 0, and the cleared input registers hold an addition of zero and zero.
- R2: The result for the operands and code presented before rising edge k is visible on the outputs after rising edge k+1. One new operation is accepted on every cycle, and results leave in the order their operations arrived.
- R3: Code 0 adds the operands with a carry-in of 0. `{carryOut, result}` equals the 9-bit sum `opA + opB`, and carries come from a Brent-Kung prefix network.
- R4: Code 1 gives `opA ^ opB`. Code 9 gives `~(opA ^ opB)`.
- R5: Code 2 gives `opA & opB`. Code 5 gives `~(opA & opB)`.
- R6: Code 3 gives `opA | opB`. Code 8 gives `~(opA | opB)`.
- R7: Code 4 gives `~opA`. Code 6 gives `~opB`. Code 7 passes `opA` through unchanged.
- R8: `carryOut` is 0 for every code other than 0.
- R9: Codes 10 to 15 give a `result` of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on the rising edge |
| rst | input | 1 | Active-high synchronous reset |
| opA | input | 8 | First operand |
| opB | input | 8 | Second operand |
| funcSel | input | 4 | Function code (0 add, 1 xor, 2 and, 3 or, 4 not A, 5 nand, 6 not B, 7 pass A, 8 nor, 9 xnor) |
| result | output | 8 | Registered result |
| carryOut | output | 1 | Registered carry-out of the addition, 0 for other codes |

## Verification
Every result and carry-out is due two rising edges after its operands and code are presented. Only the reset clear shows up one edge after the reset edge. The bench drives a new operation at each falling edge and holds a two-deep queue of expected values. Each result is compared at the falling edge two cycles after its operation was driven. A directed case checks that the output still reads the previous value one edge after a new operation is presented. The bound checker applies the same two-cycle offset with `$past(...,2)`. It keeps these checks off until two edges have passed since reset.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Function codes carried on funcSel
  typedef enum logic [3:0] {
    FN_ADD   = 4'd0,
    FN_XOR   = 4'd1,
    FN_AND   = 4'd2,
    FN_OR    = 4'd3,
    FN_NOTA  = 4'd4,
    FN_NAND  = 4'd5,
    FN_NOTB  = 4'd6,
    FN_PASSA = 4'd7,
    FN_NOR   = 4'd8,
    FN_XNOR  = 4'd9
  } aluFunc_e;

  // Bitwise kernel picked by the control
  typedef enum logic [2:0] {
    BASE_AND = 3'd0,
    BASE_OR  = 3'd1,
    BASE_XOR = 3'd2,
    BASE_A   = 3'd3,
    BASE_B   = 3'd4
  } baseOp_e;

  // Source of the output register
  typedef enum logic [1:0] {
    RES_ZERO  = 2'd0,
    RES_SUM   = 2'd1,
    RES_LOGIC = 2'd2
  } resSel_e;

  typedef struct packed {
    resSel_e resSel;
    baseOp_e baseOp;
    logic    invOut;
    logic    carryEn;
  } aluStrobes_t;

endpackage

// File: rtl/bk_adder.sv
// Brent-Kung prefix adder, carry-in fixed at 0. WIDTH must be a power of two >= 2.
module bk_adder #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] addA,
  input  logic [WIDTH-1:0] addB,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);
  localparam int LG     = $clog2(WIDTH);
  localparam int STAGES = 2 * LG;

  logic [WIDTH-1:0] gS [0:STAGES-1];
  logic [WIDTH-1:0] pS [0:STAGES-2];
  logic [WIDTH-1:0] pBit;
  logic [WIDTH:0]   carry;

  assign pBit  = addA ^ addB;
  assign gS[0] = addA & addB;
  assign pS[0] = pBit;

  // Stages 1..LG reduce upward; stages LG+1..2LG-1 fill in the remaining group carries
  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      localparam int  LVL  = (s <= LG) ? s : (STAGES - s);
      localparam int  SPAN = 1 << (LVL - 1);
      localparam int  MOD  = 1 << LVL;
      localparam bit  COMB = (s <= LG) ? (((i + 1) % MOD) == 0)
                                       : ((i >= MOD) && (((i + 1) % MOD) == SPAN));
      if (COMB) begin : g_node
        assign gS[s][i] = gS[s-1][i] | (pS[s-1][i] & gS[s-1][i-SPAN]);
        if (s < STAGES - 1) begin : g_p
          assign pS[s][i] = pS[s-1][i] & pS[s-1][i-SPAN];
        end
      end else begin : g_pass
        assign gS[s][i] = gS[s-1][i];
        if (s < STAGES - 1) begin : g_p
          assign pS[s][i] = pS[s-1][i];
        end
      end
    end
  end

  assign carry[0] = 1'b0;
  assign carry[WIDTH:1] = gS[STAGES-1];
  assign sum  = pBit ^ carry[WIDTH-1:0];
  assign cout = carry[WIDTH];
endmodule

// File: rtl/alu_ctrl.sv
// Registers the function code and decodes it into datapath strobes.
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [FUNC_W-1:0] funcSel,
  output aluStrobes_t       strobes
);
  logic [FUNC_W-1:0] funcQ;

  always_ff @(posedge clk) begin
    if (rst) funcQ <= '0;
    else     funcQ <= funcSel;
  end

  always_comb begin
    strobes = '{resSel: RES_ZERO, baseOp: BASE_AND, invOut: 1'b0, carryEn: 1'b0};
    case (funcQ)
      FN_ADD:   begin strobes.resSel = RES_SUM; strobes.carryEn = 1'b1; end
      FN_XOR:   begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_XOR; end
      FN_AND:   begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_AND; end
      FN_OR:    begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_OR;  end
      FN_NOTA:  begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_A; strobes.invOut = 1'b1; end
      FN_NAND:  begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_AND; strobes.invOut = 1'b1; end
      FN_NOTB:  begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_B; strobes.invOut = 1'b1; end
      FN_PASSA: begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_A; end
      FN_NOR:   begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_OR;  strobes.invOut = 1'b1; end
      FN_XNOR:  begin strobes.resSel = RES_LOGIC; strobes.baseOp = BASE_XOR; strobes.invOut = 1'b1; end
      default:  strobes.resSel = RES_ZERO;
    endcase
  end
endmodule

// File: rtl/alu_datapath.sv
// Operand registers, prefix adder, bitwise kernel, result mux and output registers.
module alu_datapath
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);
  logic [WIDTH-1:0] aQ, bQ;
  logic [WIDTH-1:0] sumVal, baseVal, logicVal, resNext;
  logic             addCarry, carryNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      aQ <= '0;
      bQ <= '0;
    end else begin
      aQ <= opA;
      bQ <= opB;
    end
  end

  bk_adder #(.WIDTH(WIDTH)) adder_i (
    .addA (aQ),
    .addB (bQ),
    .sum  (sumVal),
    .cout (addCarry)
  );

  always_comb begin
    case (strobes.baseOp)
      BASE_AND: baseVal = aQ & bQ;
      BASE_OR:  baseVal = aQ | bQ;
      BASE_XOR: baseVal = aQ ^ bQ;
      BASE_A:   baseVal = aQ;
      BASE_B:   baseVal = bQ;
      default:  baseVal = '0;
    endcase
    logicVal = strobes.invOut ? ~baseVal : baseVal;
    case (strobes.resSel)
      RES_SUM:   resNext = sumVal;
      RES_LOGIC: resNext = logicVal;
      default:   resNext = '0;
    endcase
    carryNext = strobes.carryEn & addCarry;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result   <= '0;
      carryOut <= 1'b0;
    end else begin
      result   <= resNext;
      carryOut <= carryNext;
    end
  end
endmodule

// File: rtl/alu_top.sv
module alu_top
  import alu_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int FUNC_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WIDTH-1:0]  opA,
  input  logic [WIDTH-1:0]  opB,
  input  logic [FUNC_W-1:0] funcSel,
  output logic [WIDTH-1:0]  result,
  output logic              carryOut
);
  aluStrobes_t strobes;

  alu_ctrl #(.FUNC_W(FUNC_W)) ctrl_i (
    .clk     (clk),
    .rst     (rst),
    .funcSel (funcSel),
    .strobes (strobes)
  );

  alu_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .rst      (rst),
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut)
  );
endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH  = 8,
  parameter int FUNC_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [WIDTH-1:0]  opA,
  input logic [WIDTH-1:0]  opB,
  input logic [FUNC_W-1:0] funcSel,
  input logic [WIDTH-1:0]  result,
  input logic              carryOut
);
  logic [1:0] sinceRst;
  logic       rstQ;
  logic       armed;

  always_ff @(posedge clk) begin
    rstQ <= rst;
    if (rst)                sinceRst <= 2'd0;
    else if (sinceRst != 2) sinceRst <= sinceRst + 2'd1;
  end

  assign armed = (sinceRst == 2'd2);

  // R1: outputs read zero after a reset edge
  always @(posedge clk) begin
    if (rstQ === 1'b1) begin
      a_reset_clear_r1: assert (result == '0 && carryOut == 1'b0)
        else $error("reset did not clear outputs");
    end
  end

  p_add_sum_r3: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) == 4'd0) |->
      ({carryOut, result} == ({1'b0, $past(opA, 2)} + {1'b0, $past(opB, 2)})));

  p_xor_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) == 4'd1) |-> (result == ($past(opA, 2) ^ $past(opB, 2))));

  p_nand_r5: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) == 4'd5) |-> (result == ~($past(opA, 2) & $past(opB, 2))));

  p_nor_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) == 4'd8) |-> (result == ~($past(opA, 2) | $past(opB, 2))));

  p_pass_a_r7: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) == 4'd7) |-> (result == $past(opA, 2)));

  p_no_carry_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) != 4'd0) |-> (carryOut == 1'b0));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(funcSel, 2) > 4'd9) |-> (result == '0));
endmodule

bind alu_top alu_checker #(.WIDTH(WIDTH), .FUNC_W(FUNC_W)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .opA      (opA),
  .opB      (opB),
  .funcSel  (funcSel),
  .result   (result),
  .carryOut (carryOut)
);

// File: tb/alu_top_tb_top.sv
module alu_top_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] a, b;
  logic [3:0]   f;
  wire  [W-1:0] res;
  wire          co;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [W:0] pipe0, pipe1;
  logic [3:0] fn0, fn1;
  bit         v0, v1;

  always #10 clk = ~clk;

  alu_top #(.WIDTH(W), .FUNC_W(4)) dut_i (
    .clk(clk), .rst(rst), .opA(a), .opB(b), .funcSel(f), .result(res), .carryOut(co)
  );

  function automatic logic [W:0] model(input logic [3:0] fn, input logic [W-1:0] x, input logic [W-1:0] y);
    case (fn)
      4'd0: return {1'b0, x} + {1'b0, y};
      4'd1: return {1'b0, x ^ y};
      4'd2: return {1'b0, x & y};
      4'd3: return {1'b0, x | y};
      4'd4: return {1'b0, ~x};
      4'd5: return {1'b0, ~(x & y)};
      4'd6: return {1'b0, ~y};
      4'd7: return {1'b0, x};
      4'd8: return {1'b0, ~(x | y)};
      4'd9: return {1'b0, ~(x ^ y)};
      default: return '0;
    endcase
  endfunction

  function automatic string reqOf(input logic [3:0] fn);
    case (fn)
      4'd0:       return "R3";
      4'd1, 4'd9: return "R4";
      4'd2, 4'd5: return "R5";
      4'd3, 4'd8: return "R6";
      4'd4, 4'd6, 4'd7: return "R7";
      default:    return "R9";
    endcase
  endfunction

  task automatic checkVal(input string req, input string what, input logic [W:0] act, input logic [W:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic checkOut(input logic [3:0] fn, input logic [W:0] exp);
    checkVal(reqOf(fn), "result", {1'b0, res}, {1'b0, exp[W-1:0]});
    checkVal((fn == 4'd0) ? "R3" : "R8", "carryOut", {{W{1'b0}}, co}, {{W{1'b0}}, exp[W]});
  endtask

  // Drive one operation at a falling edge; check the one driven two falling edges earlier (R2)
  task automatic step(input logic [3:0] fn, input logic [W-1:0] x, input logic [W-1:0] y);
    @(negedge clk);
    if (v1) checkOut(fn1, pipe1);
    pipe1 = pipe0; fn1 = fn0; v1 = v0;
    f = fn; a = x; b = y;
    pipe0 = model(fn, x, y); fn0 = fn; v0 = 1'b1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nFail++;
      $display("FAIL R2 watchdog: actual still running, expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5107));
    rst = 1'b1; a = 8'hA5; b = 8'h3C; f = 4'd2;
    v0 = 0; v1 = 0; pipe0 = '0; pipe1 = '0; fn0 = '0; fn1 = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1", "result after reset", {1'b0, res}, '0);
    checkVal("R1", "carryOut after reset", {{W{1'b0}}, co}, '0);
    rst = 1'b0;
    a = 8'd3; b = 8'd4; f = 4'd0;
    @(negedge clk);
    // R2: one edge in, output still shows the cleared registers' zero add
    checkVal("R2", "not yet due", {co, res}, 9'd0);
    @(negedge clk);
    checkVal("R2", "due after two edges", {co, res}, 9'd7);

    // Directed corners for the adder (R3) and every code (R4-R9)
    step(4'd0, 8'hFF, 8'h01);
    step(4'd0, 8'hFF, 8'hFF);
    step(4'd0, 8'h80, 8'h80);
    step(4'd0, 8'h55, 8'hAA);
    step(4'd0, 8'h00, 8'h00);
    for (int c = 0; c < 16; c++) begin
      step(c[3:0], 8'hFF, 8'hFF);
      step(c[3:0], 8'hC3, 8'h5A);
      step(c[3:0], 8'h00, 8'hFF);
    end

    // Random stream, back to back
    for (int n = 0; n < 3000; n++) begin
      step(4'($urandom_range(15)), 8'($urandom), 8'($urandom));
    end

    // Mid-stream reset (R1)
    @(negedge clk);
    rst = 1'b1; a = 8'hFF; b = 8'hFF; f = 4'd0;
    v0 = 0; v1 = 0;
    @(negedge clk);
    checkVal("R1", "result after mid reset", {1'b0, res}, '0);
    checkVal("R1", "carryOut after mid reset", {{W{1'b0}}, co}, '0);
    rst = 1'b0;
    step(4'd0, 8'hF0, 8'h1F);
    step(4'd7, 8'h9C, 8'h00);
    step(4'd0, 8'h00, 8'h00);
    step(4'd0, 8'h00, 8'h00);

    done = 1;
    summary();
    $finish;
  end
endmodule